// File: doc/BRIEF.md
# Page-Mode Controller for Multiplexed-Address Dynamic Memory

This block turns single-bit host accesses into strobe sequences for a group of 16K-by-1 dynamic memory devices that share one 7-bit address bus. A host word address of 14 bits is cut into a row half (upper seven bits) and a column half (lower seven bits). The row half goes onto the bus and is captured when the shared row strobe falls. The column half follows and is captured when the column strobe of the selected bank falls.

Every bank sees the same row strobe, but each bank has its own column strobe. The column strobe therefore acts as the chip select, and one open row spans all banks. While the row strobe stays low, a later access to the same row, in any bank, cycles only the column address and strobe. An access to a different row closes the page and waits out a precharge time before the new row strobe. An external refresh scheduler asks for a strobe-row-only refresh through a request/grant pair. A fault input forces every strobe high at once.

The host waits for `ready` before it offers a request. Read data comes back with a one-cycle valid pulse.

Top module: `dram_page_ctrl`

## Requirements
- R1: A request is accepted only on a clock edge where both `req_valid` and `ready` are high. When a new row is opened, `mem_addr` carries `req_addr[13:7]` for one cycle before `mem_ras_n` falls, and it holds that value on the falling edge.
- R2: `mem_addr` carries `req_addr[6:0]` for one cycle before the selected column strobe falls. `mem_we_n` is low for a write and high for a read, and `mem_dq_out` carries `req_wdata`. All three are already valid then, and they are still valid on the falling edge.
- R3: A request to the row that is already open (page hit), in any bank, leaves `mem_ras_n` low and causes no new row-strobe fall. `ready` stays low for exactly 1+T_CAS cycles after acceptance.
- R4: With no row open, `ready` stays low for 2+T_RCD+T_CAS cycles after acceptance. For a request to a different row than the open one, `mem_ras_n` first rises, and `ready` stays low for T_RP+2+T_RCD+T_CAS cycles. In both cases the row strobe falls exactly once.
- R5: Only `mem_cas_n[req_bank]` pulses for an access, with exactly one falling edge. At most one column strobe is ever low, and a column strobe is low only while `mem_ras_n` is low.
- R6: For a read, `rd_valid` pulses for one cycle exactly T_RD clocks after the column strobe falls. `rd_data` is the value of `mem_dq_in` at that point. A write produces no `rd_valid`.
- R7: A write stores `req_wdata` at the addressed cell of the selected bank, so a later read of that cell returns it.
- R8: While `ref_req` is high and the controller is idle, it closes any open row (rise, then T_RP precharge). It then drives `ref_row` and lowers `mem_ras_n` for T_RAS cycles, with no column strobe. After that it raises the row strobe and pulses `ref_gnt` for one cycle. The page is closed afterwards.
- R9: `ready` is low while an access, a precharge or a refresh is in progress, while `ref_req` is high, and while `fault` is high. A `req_valid` seen while `ready` is low is ignored: it causes no strobe and no memory change.
- R10: While `fault` is high, `mem_ras_n`, every `mem_cas_n` bit and `mem_we_n` are high in the same cycle. The access in progress is dropped with no `rd_valid`, and the page is closed.
- R11: After reset all strobes are high, `rd_valid` and `ref_gnt` are low, `ready` is high, and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_addr | input | 14 | Word address: row half high, column half low |
| req_bank | input | 2 | Bank select |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Write data bit |
| ready | output | 1 | Request can be accepted this cycle |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | 1 | Read data bit |
| ref_req | input | 1 | Refresh request from scheduler, held until grant |
| ref_row | input | 7 | Row to refresh, stable while `ref_req` is high |
| ref_gnt | output | 1 | One-cycle pulse when the refresh row cycle is done |
| fault | input | 1 | Forces all strobes inactive and aborts |
| mem_addr | output | 7 | Shared multiplexed address bus |
| mem_ras_n | output | 1 | Row strobe, common to all banks |
| mem_cas_n | output | 4 | Column strobe, one per bank |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 1 | Write data to devices |
| mem_dq_in | input | 1 | Read data from devices |

## Verification
The embedded assertions check four things on every clock:
- the address bus and write enable hold still across each strobe fall;
- no more than one column strobe is low, and only under a low row strobe;
- the refresh grant arrives with all strobes high;
- the strobe registers go inactive after any fault cycle.

Other behaviours show only in the bench scenarios, where a cell model keeps what is written:
- cycle counts for page hit, closed page and row miss;
- pages that span banks;
- the read-data delay;
- refresh closing an open row;
- ignored requests while busy;
- the page state after a fault.

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int HALF_W = 7,
  parameter int NBANK  = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 4,
  parameter int T_RD   = 2,
  localparam int AW = 2 * HALF_W,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [BW-1:0]     req_bank,
  input  logic              req_we,
  input  logic              req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic              rd_data,
  input  logic              ref_req,
  input  logic [HALF_W-1:0] ref_row,
  output logic              ref_gnt,
  input  logic              fault,
  output logic [HALF_W-1:0] mem_addr,
  output logic              mem_ras_n,
  output logic [NBANK-1:0]  mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_dq_out,
  input  logic              mem_dq_in
);

  localparam int CW = 8;
  localparam logic [CW-1:0] RCD_L = CW'(T_RCD - 1);
  localparam logic [CW-1:0] CAS_L = CW'(T_CAS - 1);
  localparam logic [CW-1:0] RP_L  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RAS_L = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RD_AT = CW'(T_CAS - T_RD);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_RADR, S_RCD, S_CADR, S_COL, S_REF} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic              ras_q, we_q, dq_q, open_q, pend_req, pend_ref;
  logic [NBANK-1:0]  cas_q;
  logic [HALF_W-1:0] addr_q, open_row, p_row, p_col;
  logic [BW-1:0]     p_bank;
  logic              p_we, p_data;

  wire [HALF_W-1:0] req_row = req_addr[AW-1:HALF_W];
  wire [HALF_W-1:0] req_col = req_addr[HALF_W-1:0];

  assign ready      = (state == S_IDLE) && !ref_req && !fault;
  assign mem_addr   = addr_q;
  assign mem_ras_n  = ras_q | fault;
  assign mem_cas_n  = cas_q | {NBANK{fault}};
  assign mem_we_n   = we_q | fault;
  assign mem_dq_out = dq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  cnt <= '0;
      ras_q <= 1'b1;    cas_q <= '1;   we_q <= 1'b1;  dq_q <= 1'b0;
      open_q <= 1'b0;   pend_req <= 1'b0; pend_ref <= 1'b0;
      addr_q <= '0;     open_row <= '0;  p_row <= '0;  p_col <= '0;
      p_bank <= '0;     p_we <= 1'b0;    p_data <= 1'b0;
      rd_valid <= 1'b0; rd_data <= 1'b0; ref_gnt <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      ref_gnt  <= 1'b0;
      if (fault) begin
        state <= S_PRE;  cnt <= RP_L;
        ras_q <= 1'b1;   cas_q <= '1;  we_q <= 1'b1;
        open_q <= 1'b0;  pend_req <= 1'b0; pend_ref <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (ref_req) begin
              pend_ref <= 1'b1;
              if (open_q) begin
                ras_q <= 1'b1; open_q <= 1'b0; cnt <= RP_L; state <= S_PRE;
              end else begin
                addr_q <= ref_row; state <= S_RADR;
              end
            end else if (req_valid) begin
              p_row <= req_row; p_col <= req_col; p_bank <= req_bank;
              p_we <= req_we;   p_data <= req_wdata;
              if (open_q && req_row == open_row) begin
                addr_q <= req_col; we_q <= !req_we; dq_q <= req_wdata;
                state <= S_CADR;
              end else if (open_q) begin
                ras_q <= 1'b1; open_q <= 1'b0; pend_req <= 1'b1;
                cnt <= RP_L;   state <= S_PRE;
              end else begin
                addr_q <= req_row; open_row <= req_row; state <= S_RADR;
              end
            end
          end
          S_PRE: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (pend_ref) begin
              addr_q <= ref_row; state <= S_RADR;
            end else if (pend_req) begin
              pend_req <= 1'b0; addr_q <= p_row; open_row <= p_row;
              state <= S_RADR;
            end else state <= S_IDLE;
          end
          S_RADR: begin
            ras_q <= 1'b0;
            if (pend_ref) begin
              cnt <= RAS_L; state <= S_REF;
            end else begin
              open_q <= 1'b1; cnt <= RCD_L; state <= S_RCD;
            end
          end
          S_RCD: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              addr_q <= p_col; we_q <= !p_we; dq_q <= p_data; state <= S_CADR;
            end
          end
          S_CADR: begin
            cas_q[p_bank] <= 1'b0; cnt <= CAS_L; state <= S_COL;
          end
          S_COL: begin
            if (!p_we && cnt == RD_AT) begin
              rd_valid <= 1'b1; rd_data <= mem_dq_in;
            end
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              cas_q <= '1; we_q <= 1'b1; state <= S_IDLE;
            end
          end
          S_REF: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              ras_q <= 1'b1; pend_ref <= 1'b0; ref_gnt <= 1'b1;
              cnt <= RP_L;   state <= S_PRE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_one_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cas_n));
  assert_cas_under_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~mem_cas_n)) |-> !mem_ras_n);
  assert_row_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> $stable(mem_addr));
  assert_col_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(~mem_cas_n)) && (&$past(mem_cas_n))) |-> ($stable(mem_addr) && $stable(mem_we_n) && $stable(mem_dq_out)));
  assert_gnt_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (mem_ras_n && (&mem_cas_n)));
  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> (ras_q && (&cas_q) && !rd_valid));

endmodule

// File: tb/dram_page_ctrl_tb.sv
module dram_page_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAS = 4, T_RD = 2;
  localparam int K_CLOSED = 0, K_HIT = 1, K_MISS = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_wdata = 0, ref_req = 0, fault = 0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_bank = '0;
  logic [6:0]  ref_row = '0;
  logic ready, rd_valid, rd_data, ref_gnt, mem_ras_n, mem_we_n, mem_dq_out;
  logic mem_dq_in = 0;
  logic [6:0] mem_addr;
  logic [3:0] mem_cas_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_ctrl #(.HALF_W(7), .NBANK(4), .T_RCD(T_RCD), .T_CAS(T_CAS),
                   .T_RP(T_RP), .T_RAS(T_RAS), .T_RD(T_RD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_bank(req_bank), .req_we(req_we), .req_wdata(req_wdata),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_row(ref_row), .ref_gnt(ref_gnt), .fault(fault),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in));

  int checks = 0, errors = 0;
  bit finished = 0;

  // device model and observation counters
  bit mem [int];
  bit exp_mem [int];
  int cyc = 0, ras_falls = 0, rd_cnt = 0, gnt_cnt = 0, cas_cyc = 0, rd_cyc = 0;
  int cas_cnt [4] = '{0, 0, 0, 0};
  logic [6:0] m_row = '0, m_col = '0;
  logic m_we = 1, m_dout = 0, rd_last = 0, prev_ras = 1;
  logic [3:0] prev_cas = 4'hF;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (prev_ras && !mem_ras_n) begin ras_falls++; m_row = mem_addr; end
    for (int b = 0; b < 4; b++) begin
      if (prev_cas[b] && !mem_cas_n[b]) begin
        cas_cnt[b]++; m_col = mem_addr; m_we = mem_we_n; m_dout = mem_dq_out;
        cas_cyc = cyc;
        if (!mem_we_n) mem[b*16384 + int'(m_row)*128 + int'(mem_addr)] = mem_dq_out;
        else mem_dq_in = mem.exists(b*16384 + int'(m_row)*128 + int'(mem_addr)) ?
                         mem[b*16384 + int'(m_row)*128 + int'(mem_addr)] : 1'b0;
      end
    end
    if (rd_valid) begin rd_cnt++; rd_last = rd_data; rd_cyc = cyc; end
    if (ref_gnt) gnt_cnt++;
    prev_ras = mem_ras_n; prev_cas = mem_cas_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input int kind);
    if (kind == K_HIT) return 1 + T_CAS;
    if (kind == K_CLOSED) return 2 + T_RCD + T_CAS;
    return T_RP + 2 + T_RCD + T_CAS;
  endfunction

  task automatic access(input logic we, input logic d, input logic [1:0] bank,
                        input logic [13:0] a, input int kind, input bit poke);
    int r0, rd0, lat, key;
    int c0 [4];
    while (!ready) @(negedge clk);
    r0 = ras_falls; rd0 = rd_cnt;
    for (int b = 0; b < 4; b++) c0[b] = cas_cnt[b];
    key = int'(bank)*16384 + int'(a);
    req_valid = 1; req_we = we; req_wdata = d; req_bank = bank; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!ready) begin
      lat++;
      if (poke && lat == 1) begin
        req_valid = 1; req_we = 1; req_wdata = 1; req_bank = 2'd0; req_addr = {7'd127, 7'd0};
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    check(lat == lat_of(kind), (kind == K_HIT) ? "R3 hit latency" : "R4 open/miss latency",
          lat, lat_of(kind));
    check((ras_falls - r0) == ((kind == K_HIT) ? 0 : 1),
          (kind == K_HIT) ? "R3 row strobe held" : "R4 single row strobe fall",
          ras_falls - r0, (kind == K_HIT) ? 0 : 1);
    for (int b = 0; b < 4; b++)
      check((cas_cnt[b] - c0[b]) == ((b == int'(bank)) ? 1 : 0),
            poke ? "R9 busy request ignored / R5 decode" : "R5 column strobe decode",
            cas_cnt[b] - c0[b], (b == int'(bank)) ? 1 : 0);
    check(m_row == a[13:7], "R1 row half captured", int'(m_row), int'(a[13:7]));
    check(m_col == a[6:0], "R2 column half captured", int'(m_col), int'(a[6:0]));
    check(m_we == !we, "R2 write enable at column strobe", int'(m_we), int'(!we));
    if (we) begin
      check(m_dout == d, "R2 write data at column strobe", int'(m_dout), int'(d));
      check(rd_cnt == rd0, "R6 no read pulse on write", rd_cnt - rd0, 0);
      exp_mem[key] = d;
    end else begin
      check(rd_cnt - rd0 == 1, "R6 one read pulse", rd_cnt - rd0, 1);
      check(rd_cyc - cas_cyc == T_RD, "R6 read delay", rd_cyc - cas_cyc, T_RD);
      check(rd_last == (exp_mem.exists(key) ? exp_mem[key] : 1'b0), "R7 read returns written data",
            int'(rd_last), exp_mem.exists(key) ? int'(exp_mem[key]) : 0);
    end
  endtask

  task automatic refresh(input logic [6:0] row, input bit was_open);
    int r0, g0, c;
    int c0 [4];
    while (!ready) @(negedge clk);
    r0 = ras_falls; g0 = gnt_cnt;
    for (int b = 0; b < 4; b++) c0[b] = cas_cnt[b];
    ref_req = 1; ref_row = row;
    #1;
    check(ready == 0, "R9 ready low on refresh request", int'(ready), 0);
    if (was_open) begin
      @(negedge clk);
      check(mem_ras_n == 1, "R8 open row closed first", int'(mem_ras_n), 1);
    end
    c = 0;
    while (gnt_cnt == g0 && c < 100) begin @(negedge clk); c++; end
    ref_req = 0;
    check(gnt_cnt - g0 == 1, "R8 grant pulse", gnt_cnt - g0, 1);
    check(ras_falls - r0 == 1, "R8 one row strobe", ras_falls - r0, 1);
    check(m_row == row, "R8 refresh row on bus", int'(m_row), int'(row));
    for (int b = 0; b < 4; b++)
      check(cas_cnt[b] == c0[b], "R8 no column strobe", cas_cnt[b] - c0[b], 0);
  endtask

  // {we, data, bank[1:0], kind[1:0], addr[13:0]}
  localparam logic [19:0] VEC [11] = '{
    {1'b1, 1'b1, 2'd0, 2'd0, 7'd5,   7'd3},
    {1'b1, 1'b0, 2'd1, 2'd1, 7'd5,   7'd3},
    {1'b0, 1'b0, 2'd0, 2'd1, 7'd5,   7'd3},
    {1'b0, 1'b0, 2'd1, 2'd1, 7'd5,   7'd3},
    {1'b1, 1'b1, 2'd2, 2'd2, 7'd9,   7'd127},
    {1'b1, 1'b1, 2'd3, 2'd1, 7'd9,   7'd0},
    {1'b0, 1'b0, 2'd2, 2'd1, 7'd9,   7'd127},
    {1'b0, 1'b0, 2'd0, 2'd2, 7'd127, 7'd0},
    {1'b1, 1'b1, 2'd0, 2'd1, 7'd127, 7'd64},
    {1'b0, 1'b0, 2'd0, 2'd1, 7'd127, 7'd64},
    {1'b0, 1'b0, 2'd3, 2'd2, 7'd9,   7'd0}
  };

  initial begin
    int rd0;
    repeat (3) @(negedge clk);
    check(mem_ras_n == 1 && mem_cas_n == 4'hF, "R11 strobes high in reset",
          int'({mem_ras_n, mem_cas_n}), 31);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1, "R11 ready after reset", int'(ready), 1);
    check(rd_valid == 0 && ref_gnt == 0, "R11 pulses low after reset",
          int'({rd_valid, ref_gnt}), 0);

    for (int i = 0; i < 11; i++)
      access(VEC[i][19], VEC[i][18], VEC[i][17:16], VEC[i][13:0], int'(VEC[i][15:14]), i == 3);

    refresh(7'd42, 1'b1);
    access(1'b0, 1'b0, 2'd3, {7'd9, 7'd0}, K_CLOSED, 1'b0);   // R8 page closed after refresh
    refresh(7'd99, 1'b1);
    refresh(7'd0, 1'b0);

    // R10 fault in the middle of a read
    while (!ready) @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1; req_we = 0; req_bank = 2'd1; req_addr = {7'd77, 7'd5};
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    fault = 1;
    #1;
    check(mem_ras_n == 1, "R10 row strobe forced high", int'(mem_ras_n), 1);
    check(mem_cas_n == 4'hF, "R10 column strobes forced high", int'(mem_cas_n), 15);
    check(ready == 0, "R9 ready low during fault", int'(ready), 0);
    repeat (2) @(negedge clk);
    fault = 0;
    while (!ready) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rd_cnt == rd0, "R10 aborted read gives no pulse", rd_cnt - rd0, 0);
    access(1'b0, 1'b0, 2'd1, {7'd77, 7'd5}, K_CLOSED, 1'b0);  // R10 page closed after fault

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule